// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Generator

This block sits between a processor bus and up to four external devices. It holds a small configuration store with three byte registers per channel: a control byte, a low byte and a high byte. On every bus request it tests each channel against the request, keeps only the lowest-numbered channel that matches, and pulls that channel's active-low select line. It also drives the request strobe for the current space and holds a ready output low for the channel's programmed number of wait states.

Each channel serves exactly one space. A memory channel covers a range of 64 KB pages, with an inclusive lower and upper page number compared against the top address byte. An I/O channel names one 16-byte window through a 16-bit base. An on-chip RAM hit input overrides every memory channel, but it does not affect I/O channels.

Top module: `cs_wait_gen`

## Requirements
- R1: After reset every channel is disabled and configured for memory space with zero wait states. A request then lowers no select line, and `ready` is high in the first cycle of the request.
- R2: A write with `cfg_we` high updates the byte chosen by `cfg_addr`. Bits [3:2] give the channel. Bits [1:0] give the register: 0 is control, 1 is low byte, 2 is high byte, and 3 writes nothing. In the control byte, bit 3 is enable, bit 4 is the space (0 memory, 1 I/O), and bits [7:5] are the wait count.
- R3: An enabled memory channel matches during a memory request when low byte ≤ address[23:16] ≤ high byte, with both bounds inclusive.
- R4: An enabled I/O channel matches during an I/O request when address[19:4] equals {high byte, low byte}.
- R5: A disabled channel never asserts. A memory channel never asserts in an I/O cycle, and an I/O channel never asserts in a memory cycle.
- R6: When several channels match, only the lowest-numbered one asserts, so at most one select line is low.
- R7: While `ram_hit` is high, no select line asserts in a memory cycle. I/O cycles are not affected by `ram_hit`.
- R8: `mreq_n` is low exactly while `mem_req` is high. `iorq_n` is low while `io_req` is high and `mem_req` is low. Any asserted select line coincides with one of these strobes.
- R9: For a winning channel with wait count N, `ready` stays low for the first N cycles of the request and is high in cycle N+1. With no winner, N is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Channel [3:2] and register select [1:0] |
| cfg_wdata | input | 8 | Configuration write data |
| bus_addr | input | 20 | Bus address bits [23:4] |
| mem_req | input | 1 | Memory request, held until ready |
| io_req | input | 1 | I/O request, held until ready |
| ram_hit | input | 1 | On-chip RAM claims this address |
| cs_n | output | 4 | Active-low chip selects, bit i is channel i |
| mreq_n | output | 1 | Active-low memory strobe |
| iorq_n | output | 1 | Active-low I/O strobe |
| ready | output | 1 | High in the cycle that completes the request |

## Verification
The hardest case to reach is a request that several channels match at once: two memory ranges that meet at a shared page, and two I/O channels with the same base. In that case priority alone decides which line falls. The stimulus programs overlapping channels deliberately and places addresses on both range boundaries. It then disables the winning channel in the middle of the run, so the next-lower-priority channel has to take over with its own wait count. RAM-hit overrides are driven in both memory and I/O cycles, so the bench can show that the override affects memory selects only.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int REG_W  = 8;
  localparam int WS_W   = 3;
  localparam int EN_BIT = 3;
  localparam int IO_BIT = 4;
  localparam int WS_LSB = 5;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // inclusive page window test
  function automatic logic page_in_window(input logic [REG_W-1:0] lo,
                                          input logic [REG_W-1:0] hi,
                                          input logic [REG_W-1:0] page);
    return (page >= lo) && (page <= hi);
  endfunction

  // 16-byte I/O window test against a 16-bit base
  function automatic logic io_window_hit(input logic [2*REG_W-1:0] base,
                                         input logic [2*REG_W-1:0] a);
    return base == a;
  endfunction

  // counter preload for a nonzero wait count
  function automatic logic [WS_W-1:0] wait_preload(input logic [WS_W-1:0] n);
    return n - WS_W'(1);
  endfunction
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
  import cs_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CHW-1:0]   ch,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wdata,
  output logic [NCH-1:0]   en,
  output logic [NCH-1:0]   io_sp,
  output logic [WS_W-1:0]  ws    [NCH],
  output logic [REG_W-1:0] lo    [NCH],
  output logic [REG_W-1:0] hi    [NCH]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= '0;
      io_sp <= '0;
      for (int i = 0; i < NCH; i++) begin
        ws[i] <= '0;
        lo[i] <= '0;
        hi[i] <= '0;
      end
    end else if (we) begin
      for (int i = 0; i < NCH; i++) begin
        if (ch == CHW'(i)) begin
          case (sel)
            SEL_CTRL: begin
              en[i]    <= wdata[EN_BIT];
              io_sp[i] <= wdata[IO_BIT];
              ws[i]    <= wdata[WS_LSB +: WS_W];
            end
            SEL_LO:  lo[i] <= wdata;
            SEL_HI:  hi[i] <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && ch == CHW'(i) && sel == SEL_CTRL) |=>
        (en[i] == $past(wdata[EN_BIT]) && ws[i] == $past(wdata[WS_LSB +: WS_W])));
    // R2
    none_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_NONE) |=> ($stable(lo[i]) && $stable(hi[i]) && $stable(en[i])));
  end
endmodule

// File: rtl/cs_match.sv
module cs_match
  import cs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 24
) (
  input  logic [AW-1:4]    addr,
  input  logic             mem_cyc,
  input  logic             io_cyc,
  input  logic             ram_hit,
  input  logic [NCH-1:0]   en,
  input  logic [NCH-1:0]   io_sp,
  input  logic [REG_W-1:0] lo [NCH],
  input  logic [REG_W-1:0] hi [NCH],
  output logic [NCH-1:0]   hit
);
  localparam int PAGE_LSB = AW - REG_W;

  logic [REG_W-1:0]   page;
  logic [2*REG_W-1:0] io_a;
  assign page = addr[AW-1:PAGE_LSB];
  assign io_a = addr[2*REG_W+3:4];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic mem_ok, io_ok;
    assign mem_ok = !io_sp[i] && mem_cyc && !ram_hit && page_in_window(lo[i], hi[i], page);
    assign io_ok  = io_sp[i] && io_cyc && io_window_hit({hi[i], lo[i]}, io_a);
    assign hit[i] = en[i] && (mem_ok || io_ok);
  end
endmodule

// File: rtl/cs_prio.sv
module cs_prio #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  output logic [NCH-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hit[i]) grant = NCH'(1) << i;
    end
  end

  // R6
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~hit) == '0));
  // R6
  no_lost_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |-> (grant != '0));
endmodule

// File: rtl/cs_wait.sv
module cs_wait
  import cs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [WS_W-1:0] ws,
  output logic            ready
);
  logic            busy_q;
  logic [WS_W-1:0] cnt_q;
  logic            start;

  assign start = req && !busy_q;
  assign ready = req && (busy_q ? (cnt_q == '0) : (ws == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && ws != '0) begin
      busy_q <= 1'b1;
      cnt_q  <= wait_preload(ws);
    end else if (busy_q) begin
      if (cnt_q != '0) cnt_q  <= cnt_q - WS_W'(1);
      else             busy_q <= 1'b0;
    end
  end

  // R9
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - WS_W'(1)));
  // R9
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((start && ws != '0) || (busy_q && cnt_q != '0)) |-> !ready);
  // R9
  ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> req);
endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen
  import cs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 24,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CHW+1:0]   cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [AW-1:4]    bus_addr,
  input  logic             mem_req,
  input  logic             io_req,
  input  logic             ram_hit,
  output logic [NCH-1:0]   cs_n,
  output logic             mreq_n,
  output logic             iorq_n,
  output logic             ready
);
  logic [NCH-1:0]   en, io_sp, hit, grant;
  logic [WS_W-1:0]  ws [NCH];
  logic [REG_W-1:0] lo [NCH];
  logic [REG_W-1:0] hi [NCH];
  logic [WS_W-1:0]  win_ws;
  logic             io_cyc;
  reg_sel_e         sel;

  assign io_cyc = io_req && !mem_req;
  assign sel    = reg_sel_e'(cfg_addr[1:0]);

  cs_regfile #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .ch(cfg_addr[CHW+1:2]), .sel(sel),
    .wdata(cfg_wdata), .en(en), .io_sp(io_sp), .ws(ws), .lo(lo), .hi(hi)
  );

  cs_match #(.NCH(NCH), .AW(AW)) u_match (
    .addr(bus_addr), .mem_cyc(mem_req), .io_cyc(io_cyc), .ram_hit(ram_hit),
    .en(en), .io_sp(io_sp), .lo(lo), .hi(hi), .hit(hit)
  );

  cs_prio #(.NCH(NCH)) u_prio (
    .clk(clk), .rst_n(rst_n), .hit(hit), .grant(grant)
  );

  always_comb begin
    win_ws = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) win_ws = ws[i];
    end
  end

  cs_wait u_wait (
    .clk(clk), .rst_n(rst_n), .req(mem_req || io_req), .ws(win_ws), .ready(ready)
  );

  assign cs_n   = ~grant;
  assign mreq_n = ~mem_req;
  assign iorq_n = ~io_cyc;

  // R8
  strobe_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |-> (!mreq_n || !iorq_n));
  // R7
  ram_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_hit && mem_req) |-> (cs_n == '1));
  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cs_n & ~en) == '0));
endmodule

// File: tb/cs_wait_gen_bench.sv
module cs_wait_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [23:4] bus_addr = '0;
  logic        mem_req = 1'b0, io_req = 1'b0, ram_hit = 1'b0;
  logic [3:0]  cs_n;
  logic        mreq_n, iorq_n, ready;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cs_wait_gen u_cs_wait_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .mem_req(mem_req),
    .io_req(io_req), .ram_hit(ram_hit), .cs_n(cs_n), .mreq_n(mreq_n),
    .iorq_n(iorq_n), .ready(ready)
  );

  // scoreboard queues
  logic [5:0] exp_q[$];
  int         expw_q[$];
  string      tag_q[$];
  event       done;

  task automatic wr(input int ch, input int sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(ch * 4 + sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cyc(input logic [23:0] a, input bit mem, input bit ram,
                     input logic [3:0] ecs, input int ew, input string tag);
    exp_q.push_back({ecs, !mem, mem});
    expw_q.push_back(ew);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_addr = a[23:4]; mem_req = mem; io_req = !mem; ram_hit = ram;
    @(done);
    @(negedge clk);
    mem_req = 1'b0; io_req = 1'b0; ram_hit = 1'b0;
    @(negedge clk);
  endtask

  // monitor
  initial begin
    bit         in_cyc = 0;
    int         waits = 0;
    logic [5:0] got = '0;
    forever begin
      @(negedge clk);
      #5;
      if (mem_req || io_req) begin
        if (!in_cyc) begin
          in_cyc = 1; waits = 0; got = {cs_n, mreq_n, iorq_n};
        end
        if (ready) begin
          logic [5:0] e;
          int ew;
          string t;
          e = exp_q.pop_front(); ew = expw_q.pop_front(); t = tag_q.pop_front();
          checks++;
          if (got !== e || waits != ew) begin
            errors++;
            $display("FAIL %s: actual cs_n=%b mreq_n=%b iorq_n=%b waits=%0d expected cs_n=%b mreq_n=%b iorq_n=%b waits=%0d",
                     t, got[5:2], got[1], got[0], waits, e[5:2], e[1], e[0], ew);
          end
          in_cyc = 0;
          ->done;
        end else begin
          waits++;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual=hung expected=completed");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    checks++;
    if (cs_n !== 4'hF || mreq_n !== 1'b1 || iorq_n !== 1'b1 || ready !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: actual cs_n=%b mreq_n=%b iorq_n=%b ready=%b expected 1111 1 1 0",
               cs_n, mreq_n, iorq_n, ready);
    end
    rst_n = 1'b1;
    // R1: nothing enabled out of reset
    cyc(24'h120000, 1, 0, 4'hF, 0, "R1 reset mem");
    cyc(24'h003A50, 0, 0, 4'hF, 0, "R1 reset io");
    // R2 programming; a select-3 write must not disturb ch0 low byte
    wr(0, 1, 8'h10); wr(0, 2, 8'h1F); wr(0, 3, 8'h55); wr(0, 0, 8'h48);
    wr(1, 1, 8'h18); wr(1, 2, 8'h30); wr(1, 0, 8'hA8);
    wr(2, 1, 8'hA5); wr(2, 2, 8'h03); wr(2, 0, 8'h38);
    wr(3, 1, 8'hA5); wr(3, 2, 8'h03); wr(3, 0, 8'hF8);
    cyc(24'h100000, 1, 0, 4'hE, 2, "R3 R2 lower bound ch0");
    cyc(24'h1F0000, 1, 0, 4'hE, 2, "R6 R3 overlap upper bound ch0");
    cyc(24'h200000, 1, 0, 4'hD, 5, "R3 R9 ch1");
    cyc(24'h300000, 1, 0, 4'hD, 5, "R3 upper bound ch1");
    cyc(24'h310000, 1, 0, 4'hF, 0, "R3 above range");
    cyc(24'h0FFFF0, 1, 0, 4'hF, 0, "R3 below range");
    cyc(24'h150000, 1, 1, 4'hF, 0, "R7 ram override");
    cyc(24'h003A50, 0, 1, 4'hB, 1, "R4 R6 R7 io ch2");
    cyc(24'h003A60, 0, 0, 4'hF, 0, "R4 io miss");
    cyc(24'h100000, 0, 0, 4'hF, 0, "R5 mem channel in io cycle");
    cyc(24'h003A50, 1, 0, 4'hF, 0, "R5 io channel in mem cycle");
    wr(2, 0, 8'h30);
    cyc(24'h003A5F, 0, 0, 4'h7, 7, "R5 R6 ch2 disabled ch3 wins");
    wr(0, 0, 8'h40);
    cyc(24'h1F0000, 1, 0, 4'hD, 5, "R5 ch0 disabled ch1 wins");
    wr(1, 0, 8'h08);
    cyc(24'h200000, 1, 0, 4'hD, 0, "R9 zero waits");
    wr(0, 0, 8'h08);
    cyc(24'h100000, 1, 0, 4'hE, 0, "R2 R8 ch0 reenabled lower byte kept");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule